// File: doc/BRIEF.md
# Saturating Calibration Setting Register with Nonvolatile Backup

This block keeps the calibration setting of a panel bias DAC. The setting is a small unsigned code. Strobes from an upstream level decoder move it up or down one step at a time, and it sticks at either end of its range instead of wrapping. The value shown to the DAC is the setting plus one. A setting of zero therefore still gives a nonzero output, and the top setting gives the full count.

A slow nonvolatile word keeps the tuned value across power cycles. The block saves the setting into that word when the decoder reports a programming overvoltage that stays present for longer than a qualification window, measured in microsecond ticks. It saves once per such event. When the block leaves reset, and again each time the enable input falls, it reads the word back into the setting. While a read or a write to the memory is in progress, a status flag is high and the setting cannot be adjusted.

The control sequencer has five named states. LOAD_REQ sends a one-cycle read request. LOAD_WAIT waits for the memory to finish and then captures its data. IDLE is where adjustment and qualification take place. SAVE_REQ sends a one-cycle write request. SAVE_WAIT waits for the memory to finish.

The transitions are as follows. Reset enters LOAD_REQ. LOAD_REQ always moves to LOAD_WAIT. LOAD_WAIT returns to IDLE once the memory is not busy. IDLE moves to LOAD_REQ when an enable fall is pending; otherwise it moves to SAVE_REQ when the qualified overvoltage is present with enable high. SAVE_REQ always moves to SAVE_WAIT. SAVE_WAIT returns to IDLE once the memory is not busy.

Top module: `cal_setting_ctrl`

## Requirements
- R1: The setting is W bits wide (default 7, so 128 steps). The code `dac_code` equals setting + 1, so it always lies between 1 and 2^W. At reset the setting starts at mid-scale (64 by default) before the first reload.
- R2: An increment at the maximum setting leaves the setting unchanged, and a decrement at zero leaves it unchanged. It never wraps.
- R3: In IDLE with `en` high, a cycle with `inc_stb` alone raises the setting by one, and a cycle with `dec_stb` alone lowers it by one. A cycle with both strobes leaves it unchanged.
- R4: A write begins after `prog_lvl` and `en` have both been high for QUAL_US+1 rising `us_tick` cycles. `nv_wr` pulses for one cycle, the cycle after IDLE sees the qualification, and `nv_wdata` carries the setting.
- R5: Only one write happens for each continuous assertion of `prog_lvl`. Before another write can start, `prog_lvl` must go low.
- R6: `busy` is high from the read or write request until `nv_busy` is seen low. During this time no new write starts and strobes have no effect.
- R7: A reload happens after reset and after every falling edge of `en`. `nv_rd` pulses for one cycle, and the setting takes `nv_rdata` in the first cycle where `nv_busy` is low after the request.
- R8: While `en` is low, strobes do not change the setting and `prog_lvl` never leads to a write.
- R9: Strobes that arrive while a reload is in progress are ignored. The setting after the reload equals the stored word.
- R10: The memory must raise `nv_busy` on the clock edge that follows a request and keep it high until the operation is complete. `nv_rd` and `nv_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| en | input | 1 | Adjustment enable; a falling edge starts a reload |
| inc_stb | input | 1 | One-cycle step-up strobe |
| dec_stb | input | 1 | One-cycle step-down strobe |
| prog_lvl | input | 1 | Programming overvoltage present |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| nv_rd | output | 1 | One-cycle read request to the nonvolatile word |
| nv_wr | output | 1 | One-cycle write request to the nonvolatile word |
| nv_wdata | output | W | Data to write |
| nv_rdata | input | W | Stored word |
| nv_busy | input | 1 | Memory operation in progress |
| dac_code | output | W+1 | Setting + 1, drives the DAC |
| busy | output | 1 | Reload or save in progress |

## Verification
The bench keeps the default width of 7 bits, so saturation at 1 and at 128 can be reached with about a hundred strobes. It reduces QUAL_US to 4 and pulses the tick every third cycle. With these values a qualified save fits in a few dozen cycles, and so does an assertion that is too short to qualify. The memory stub has a read latency of 3 cycles and a write latency of 12 cycles. This leaves room to send strobes into a reload and into a save, and to check that they are ignored.

// File: rtl/cal_pkg.sv
package cal_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_REQ,
        ST_LOAD_WAIT,
        ST_SAVE_REQ,
        ST_SAVE_WAIT
    } seq_state_t;
endpackage

// File: rtl/cal_sat_counter.sv
module cal_sat_counter #(
    parameter int W    = 7,
    parameter int INIT = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_ok,
    input  logic         up,
    input  logic         down,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] BOT = '0;

    logic go_up;
    logic go_down;

    // Both strobes in one cycle cancel; the end stops block any further step.
    assign go_up   = step_ok && up && !down && (value != TOP);
    assign go_down = step_ok && down && !up && (value != BOT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= W'(INIT);
        end else if (load) begin
            value <= load_val;
        end else if (go_up) begin
            value <= value + 1'b1;
        end else if (go_down) begin
            value <= value - 1'b1;
        end
    end
endmodule

// File: rtl/cal_prog_qual.sv
module cal_prog_qual #(
    parameter int QUAL_US = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_lvl,
    input  logic en,
    input  logic us_tick,
    input  logic take,
    output logic qual
);
    localparam int CW = $clog2(QUAL_US + 1);
    localparam logic [CW-1:0] LIMIT = CW'(QUAL_US);

    logic [CW-1:0] ticks;
    logic          held;
    logic          armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ticks <= '0;
            held  <= 1'b0;
        end else if (!prog_lvl || !en) begin
            ticks <= '0;
            held  <= 1'b0;
        end else if (us_tick && !held) begin
            // The tick after LIMIT counted ticks marks "longer than" the window.
            if (ticks == LIMIT) begin
                held <= 1'b1;
            end else begin
                ticks <= ticks + 1'b1;
            end
        end
    end

    // One save per assertion: disarm on use, re-arm only once the flag drops.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b1;
        end else if (take) begin
            armed <= 1'b0;
        end else if (!prog_lvl) begin
            armed <= 1'b1;
        end
    end

    assign qual = held && armed;
endmodule

// File: rtl/cal_nv_seq.sv
module cal_nv_seq
    import cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic prog_lvl,
    input  logic qual,
    input  logic nv_busy,
    output logic nv_rd,
    output logic nv_wr,
    output logic take,
    output logic load,
    output logic step_ok,
    output logic busy
);
    seq_state_t st;
    seq_state_t st_nx;
    logic       en_q;
    logic       reload_pend;
    logic       start_save;

    assign start_save = !reload_pend && qual && prog_lvl && en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q        <= 1'b0;
            reload_pend <= 1'b0;
        end else begin
            en_q <= en;
            if (en_q && !en) begin
                reload_pend <= 1'b1;
            end else if (st == ST_IDLE && reload_pend) begin
                reload_pend <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_LOAD_REQ;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (reload_pend) begin
                    st_nx = ST_LOAD_REQ;
                end else if (start_save) begin
                    st_nx = ST_SAVE_REQ;
                end
            end
            ST_LOAD_REQ:  st_nx = ST_LOAD_WAIT;
            ST_LOAD_WAIT: if (!nv_busy) st_nx = ST_IDLE;
            ST_SAVE_REQ:  st_nx = ST_SAVE_WAIT;
            ST_SAVE_WAIT: if (!nv_busy) st_nx = ST_IDLE;
            default:      st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        nv_rd   = 1'b0;
        nv_wr   = 1'b0;
        take    = 1'b0;
        load    = 1'b0;
        step_ok = 1'b0;
        busy    = 1'b1;
        unique case (st)
            ST_IDLE: begin
                busy    = 1'b0;
                step_ok = en;
                take    = start_save;
            end
            ST_LOAD_REQ:  nv_rd = 1'b1;
            ST_LOAD_WAIT: load  = !nv_busy;
            ST_SAVE_REQ:  nv_wr = 1'b1;
            ST_SAVE_WAIT: ;
            default:      busy  = 1'b1;
        endcase
    end
endmodule

// File: rtl/cal_setting_ctrl.sv
module cal_setting_ctrl #(
    parameter int W       = 7,
    parameter int MID     = 64,
    parameter int QUAL_US = 200
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         inc_stb,
    input  logic         dec_stb,
    input  logic         prog_lvl,
    input  logic         us_tick,
    output logic         nv_rd,
    output logic         nv_wr,
    output logic [W-1:0] nv_wdata,
    input  logic [W-1:0] nv_rdata,
    input  logic         nv_busy,
    output logic [W:0]   dac_code,
    output logic         busy
);
    logic         qual;
    logic         take;
    logic         load;
    logic         step_ok;
    logic [W-1:0] setting;

    cal_prog_qual #(.QUAL_US(QUAL_US)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_lvl (prog_lvl),
        .en       (en),
        .us_tick  (us_tick),
        .take     (take),
        .qual     (qual)
    );

    cal_nv_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .prog_lvl (prog_lvl),
        .qual     (qual),
        .nv_busy  (nv_busy),
        .nv_rd    (nv_rd),
        .nv_wr    (nv_wr),
        .take     (take),
        .load     (load),
        .step_ok  (step_ok),
        .busy     (busy)
    );

    cal_sat_counter #(.W(W), .INIT(MID)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_ok  (step_ok),
        .up       (inc_stb),
        .down     (dec_stb),
        .load     (load),
        .load_val (nv_rdata),
        .value    (setting)
    );

    assign nv_wdata = setting;
    assign dac_code = {1'b0, setting} + 1'b1;
endmodule

// File: rtl/cal_setting_ctrl_chk.sv
module cal_setting_ctrl_chk #(
    parameter int W = 7
) (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       inc_stb,
    input logic       dec_stb,
    input logic       prog_lvl,
    input logic       nv_rd,
    input logic       nv_wr,
    input logic       nv_busy,
    input logic [W:0] dac_code,
    input logic       busy
);
    localparam logic [W:0] TOPC = {1'b1, {W{1'b0}}};
    localparam logic [W:0] ONE  = (W+1)'(1);

    assert_dac_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dac_code != '0);

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && en && inc_stb && !dec_stb && dac_code == TOPC) |=> dac_code == TOPC);

    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && en && dec_stb && !inc_stb && dac_code == ONE) |=> dac_code == ONE);

    assert_write_qualified_R4: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wr |-> ($past(prog_lvl) && $past(en)));

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wr |=> !nv_wr);

    assert_busy_covers_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nv_busy |-> busy);

    assert_hold_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !busy) |=> $stable(dac_code));

    assert_frozen_in_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_rd || (busy && nv_busy)) |=> $stable(dac_code));

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(nv_rd && nv_wr));
endmodule

bind cal_setting_ctrl cal_setting_ctrl_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .inc_stb  (inc_stb),
    .dec_stb  (dec_stb),
    .prog_lvl (prog_lvl),
    .nv_rd    (nv_rd),
    .nv_wr    (nv_wr),
    .nv_busy  (nv_busy),
    .dac_code (dac_code),
    .busy     (busy)
);

// File: tb/tb_cal_setting_ctrl.sv
module tb_cal_setting_ctrl;
    localparam int CLK_NS  = 10;
    localparam int W       = 7;
    localparam int QUAL    = 4;
    localparam int RD_LAT  = 3;
    localparam int WR_LAT  = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b1;
    logic         inc_stb = 1'b0;
    logic         dec_stb = 1'b0;
    logic         prog_lvl = 1'b0;
    logic         us_tick = 1'b0;
    logic         nv_rd;
    logic         nv_wr;
    logic [W-1:0] nv_wdata;
    logic [W-1:0] nv_rdata;
    logic         nv_busy;
    logic [W:0]   dac_code;
    logic         busy;

    int total = 0;
    int bad = 0;
    int wr_cnt = 0;

    always #(CLK_NS/2) clk = ~clk;

    cal_setting_ctrl #(.W(W), .MID(64), .QUAL_US(QUAL)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .inc_stb(inc_stb), .dec_stb(dec_stb),
        .prog_lvl(prog_lvl), .us_tick(us_tick), .nv_rd(nv_rd), .nv_wr(nv_wr),
        .nv_wdata(nv_wdata), .nv_rdata(nv_rdata), .nv_busy(nv_busy),
        .dac_code(dac_code), .busy(busy)
    );

    // Behavioural nonvolatile word: blank part holds mid-scale.
    logic [W-1:0] nv_mem;
    logic         mem_busy;
    int           mem_left;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_busy <= 1'b0;
            mem_left <= 0;
        end else if (nv_rd || nv_wr) begin
            mem_busy <= 1'b1;
            mem_left <= nv_wr ? WR_LAT : RD_LAT;
            if (nv_wr) nv_mem <= nv_wdata;
        end else if (mem_left > 1) begin
            mem_left <= mem_left - 1;
        end else begin
            mem_busy <= 1'b0;
            mem_left <= 0;
        end
    end
    initial nv_mem = 7'd64;
    assign nv_rdata = nv_mem;
    assign nv_busy  = mem_busy;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model: phase 0 idle, 1 read request, 2 read wait, 3 write request, 4 write wait.
    int  m_set = 64, m_ph = 1, m_cnt = 0, nph = 0;
    bit  m_pend = 0, m_enq = 0, m_done = 0, m_arm = 1, m_take = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_set = 64; m_ph = 1; m_pend = 0; m_enq = 0;
            m_cnt = 0; m_done = 0; m_arm = 1;
        end else begin
            nph = m_ph;
            m_take = 0;
            case (m_ph)
                0: if (m_pend) nph = 1;
                   else if (m_done && m_arm && prog_lvl && en) begin nph = 3; m_take = 1; end
                1: nph = 2;
                2: if (!mem_busy) begin m_set = int'(nv_mem); nph = 0; end
                3: nph = 4;
                default: if (!mem_busy) nph = 0;
            endcase
            if (m_ph == 0 && en) begin
                if (inc_stb && !dec_stb && m_set < 127) m_set++;
                else if (dec_stb && !inc_stb && m_set > 0) m_set--;
            end
            if (m_enq && !en) m_pend = 1;
            else if (m_ph == 0 && m_pend) m_pend = 0;
            m_enq = en;
            if (!prog_lvl || !en) begin
                m_cnt = 0; m_done = 0;
                if (!prog_lvl) m_arm = 1;
            end else if (us_tick && !m_done) begin
                if (m_cnt == QUAL) m_done = 1; else m_cnt++;
            end
            if (m_take) m_arm = 0;
            m_ph = nph;
        end
    end

    // Per-cycle comparison against the model (R1 code mapping, R6 flag, R7/R4 requests).
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(dac_code) == m_set + 1, "R1 model dac_code", int'(dac_code), m_set + 1);
            chk(busy == (m_ph != 0), "R6 model busy", busy, m_ph != 0);
            chk(nv_rd == (m_ph == 1), "R7 model nv_rd", nv_rd, m_ph == 1);
            chk(nv_wr == (m_ph == 3), "R4 model nv_wr", nv_wr, m_ph == 3);
            if (nv_wr) wr_cnt++;
        end
    end

    // Microsecond tick every third cycle.
    initial begin
        int n = 0;
        forever begin
            @(negedge clk);
            n++;
            us_tick = (n % 3 == 0);
        end
    end

    task automatic pulse(input bit up, input bit dn, input int times);
        for (int i = 0; i < times; i++) begin
            @(negedge clk); inc_stb = up; dec_stb = dn;
            @(negedge clk); inc_stb = 1'b0; dec_stb = 1'b0;
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic hold_prog(input int ticks);
        int seen = 0;
        @(negedge clk); prog_lvl = 1'b1;
        while (seen < ticks) begin
            @(negedge clk);
            if (us_tick) seen++;
        end
        prog_lvl = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 150000);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: strobe during power-up reload is dropped
        pulse(1'b1, 1'b0, 1);
        chk(busy == 1'b1, "R9 busy during power-up reload", busy, 1);
        wait_idle();
        chk(dac_code == 8'd65, "R7 power-up reload of blank word", dac_code, 65);

        // R3 stepping and cancellation
        pulse(1'b1, 1'b0, 5);
        chk(dac_code == 8'd70, "R3 five increments", dac_code, 70);
        pulse(1'b0, 1'b1, 2);
        chk(dac_code == 8'd68, "R3 two decrements", dac_code, 68);
        pulse(1'b1, 1'b1, 3);
        chk(dac_code == 8'd68, "R3 both strobes cancel", dac_code, 68);

        // R2 saturation at both ends
        pulse(1'b1, 1'b0, 100);
        chk(dac_code == 8'd128, "R2 saturate high", dac_code, 128);
        pulse(1'b0, 1'b1, 200);
        chk(dac_code == 8'd1, "R2 saturate low", dac_code, 1);

        // R8: enable low reloads, then strobes and overvoltage have no effect
        en = 1'b0;
        repeat (3) @(negedge clk);
        wait_idle();
        chk(dac_code == 8'd65, "R7 reload on enable fall", dac_code, 65);
        pulse(1'b1, 1'b0, 4);
        chk(dac_code == 8'd65, "R8 strobes ignored while disabled", dac_code, 65);
        hold_prog(20);
        chk(wr_cnt == 0, "R8 no write while disabled", wr_cnt, 0);

        en = 1'b1;
        repeat (3) @(negedge clk);
        pulse(1'b0, 1'b1, 35);
        chk(dac_code == 8'd30, "R3 move to 30", dac_code, 30);

        // R4: too short an assertion does not write
        hold_prog(3);
        chk(wr_cnt == 0, "R4 short overvoltage rejected", wr_cnt, 0);

        // R4/R5/R6: long assertion writes once; strobe during save ignored
        @(negedge clk); prog_lvl = 1'b1;
        while (!busy) @(negedge clk);
        pulse(1'b1, 1'b0, 1);
        chk(busy == 1'b1, "R6 busy during save", busy, 1);
        chk(dac_code == 8'd30, "R6 strobe ignored during save", dac_code, 30);
        repeat (90) @(negedge clk);
        prog_lvl = 1'b0;
        repeat (2) @(negedge clk);
        chk(wr_cnt == 1, "R5 one write per assertion", wr_cnt, 1);
        chk(int'(nv_mem) == 29, "R4 stored setting", int'(nv_mem), 29);

        // R7/R9: change, short enable drop, strobe during reload
        pulse(1'b1, 1'b0, 3);
        chk(dac_code == 8'd33, "R3 move to 33", dac_code, 33);
        @(negedge clk); en = 1'b0;
        @(negedge clk); en = 1'b1;
        @(negedge clk);
        pulse(1'b1, 1'b0, 1);
        wait_idle();
        chk(dac_code == 8'd30, "R9 reload restores stored value", dac_code, 30);

        // R5: second assertion after the drop writes again
        hold_prog(8);
        wait_idle();
        chk(wr_cnt == 2, "R5 rearm after drop", wr_cnt, 2);
        finish_run();
    end
endmodule